// File: doc/BRIEF.md
# Cascaded Dual-Channel Timebase

This block builds one free-running time base out of two narrow counter channels. The low channel advances on a prescaled count-enable input. It also produces a square wave from two compare levels. The wave goes high when the count reaches compare A and goes low when it reaches compare C. With the default levels of 0 and half scale, this gives a 50% duty wave whose period is one full turn of the low counter. The high channel can take that wave as its clock. In that case it steps once per turn of the low counter, and together the two channels form one wide count.

Each channel counts only after its clock has been switched on, and its clock status can be read. A sync command clears both counters on the same edge. Each channel has an interrupt mask with set and clear writes. A single-channel mode lets the low channel count across the full combined width while the high channel stays idle.

Top module: `casc_timebase`

## Requirements
- R1: After reset both counters read zero, both clock status bits are 0, both interrupt outputs are 0 and the square wave is 1.
- R2: A channel counts only while its clock status bit is 1. A clock-on command sets the bit and a clock-off command clears it, both at the next edge. If both commands arrive in the same cycle, clock-off wins.
- R3: In dual mode the low count increments on each edge where tick is 1 and its clock is on. It wraps from all-ones to 0 and does not reload at compare C.
- R4: The square wave is 1 from compare A (0) through C-1 and 0 from C through all-ones. It changes on the same edge as the count.
- R5: With hi_src_sel = 1, the high count increments on exactly the edge where the low count wraps to 0, provided the high clock is on. It wraps from all-ones to 0.
- R6: With hi_src_sel = 0, the high count increments on each edge where tick is 1 and its clock is on.
- R7: In dual mode count_all equals the high count shifted left by LO_W, ORed with the low count.
- R8: sync_cmd clears both counters on the next edge. It takes priority over counting and raises no interrupt.
- R9: Interrupt mask bit 0 selects the wrap-to-0 event and bit 1 selects the low count reaching compare C; the high channel has only the wrap event. A set write ORs irq_wdata into a channel's mask. A clear write removes those bits and wins over a set write in the same cycle. irq[i] is 1 for one cycle, in the cycle that shows the new count, when a masked-in event occurs. After a clear write of 0xFF, the channel's irq stays 0.
- R10: With single_mode = 1, the low channel counts LO_W+HI_W bits wide and count_all equals that count. The high channel does not advance, so hi_count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled count enable |
| single_mode | input | 1 | 1 selects one wide counter in the low channel |
| hi_src_sel | input | 1 | High channel source: 1 = low square wave, 0 = tick |
| clk_en_cmd | input | 2 | Per-channel clock-on command (bit 0 = low, bit 1 = high) |
| clk_dis_cmd | input | 2 | Per-channel clock-off command |
| sync_cmd | input | 1 | Clear both counters |
| irq_en_wr | input | 2 | Per-channel mask set write |
| irq_dis_wr | input | 2 | Per-channel mask clear write |
| irq_wdata | input | 8 | Mask bits for set/clear writes |
| clk_on | output | 2 | Per-channel clock status |
| lo_wave | output | 1 | Low channel square wave |
| irq | output | 2 | Per-channel interrupt pulse |
| lo_count | output | LO_W | Low channel count (low LO_W bits) |
| hi_count | output | HI_W | High channel count |
| count_all | output | LO_W+HI_W | Combined count |

## Verification
Every result here is registered once. A count, the wave, an interrupt pulse or a status bit changes on the first rising edge after its command or tick is applied. Even the cascade step from a low wrap lands on that same edge. The bench drives inputs 1 ns after a rising edge and compares all outputs 1 ns after the next one. Its arithmetic model advances exactly once per edge, using the clock status held before that edge.

// File: rtl/casc_pkg.sv
// Shared constants for the cascaded timebase.
// Assumes: an interrupt mask of IRQ_W bits per channel, event bits at fixed positions.
package casc_pkg;
    localparam int IRQ_W   = 8;
    localparam int EV_WRAP = 0;  // counter wrapped to zero
    localparam int EV_CMPC = 1;  // low counter reached compare C
endpackage

// File: rtl/casc_chan_ctl.sv
// Per-channel control: clock on/off status and interrupt mask/pulse.
// Assumes: commands are single-cycle strobes; events are combinational from the
// channel logic and refer to the count being loaded at this edge.
module casc_chan_ctl
    import casc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             msk_set,
    input  logic             msk_clr,
    input  logic [IRQ_W-1:0] msk_data,
    input  logic [IRQ_W-1:0] events,
    output logic             clk_on,
    output logic             irq
);
    logic [IRQ_W-1:0] mask_q, mask_d;

    // Next mask: set bits first, clear bits override
    always_comb begin
        mask_d = mask_q;
        if (msk_set) mask_d = mask_d | msk_data;
        if (msk_clr) mask_d = mask_d & ~msk_data;
    end

    // Clock status, mask and interrupt pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_on <= 1'b0;
            mask_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (dis_cmd)     clk_on <= 1'b0;
            else if (en_cmd) clk_on <= 1'b1;
            mask_q <= mask_d;
            irq    <= |(events & mask_d);
        end
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n) dis_cmd |=> !clk_on); // R2
    AST_ON_TAKES: assert property (@(posedge clk) disable iff (!rst_n) (en_cmd && !dis_cmd) |=> clk_on); // R2
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n) (msk_clr && (&msk_data)) |=> !irq); // R9
endmodule

// File: rtl/casc_low_chan.sv
// Low channel: free-running counter with a set/clear square wave.
// Assumes: dual mode wraps at LO_W bits; wide mode uses all LO_W+HI_W bits.
// The wave follows the next count, so it and its rising-edge flag line up
// with the edge on which the count changes.
module casc_low_chan
    import casc_pkg::*;
#(
    parameter int LO_W  = 16,
    parameter int HI_W  = 16,
    parameter int CMP_A = 0,
    parameter int CMP_C = 32768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync,
    input  logic                 step,
    input  logic                 wide,
    output logic [LO_W+HI_W-1:0] cnt,
    output logic                 wave,
    output logic                 wave_rise,
    output logic [IRQ_W-1:0]     events
);
    localparam int W = LO_W + HI_W;
    localparam logic [LO_W-1:0] LVL_A = LO_W'(CMP_A);
    localparam logic [LO_W-1:0] LVL_C = LO_W'(CMP_C);
    localparam logic WAVE_RST = (CMP_A == 0);

    logic [W-1:0]    cnt_d;
    logic [LO_W-1:0] low_d;
    logic            wave_d;
    logic            adv;

    // Next count: sync clears, step increments at the mode's width
    always_comb begin
        cnt_d = cnt;
        if (sync)      cnt_d = '0;
        else if (step) cnt_d = wide ? cnt + W'(1)
                                    : {{HI_W{1'b0}}, cnt[LO_W-1:0] + LO_W'(1)};
        low_d = cnt_d[LO_W-1:0];
    end

    // Next wave level from the compare matches on the next count
    always_comb begin
        wave_d = wave;
        if (low_d == LVL_A)      wave_d = 1'b1;
        else if (low_d == LVL_C) wave_d = 1'b0;
    end

    // Event flags and cascade edge for the current edge
    always_comb begin
        adv = step & ~sync;
        events = '0;
        events[EV_WRAP] = adv & (wide ? (cnt_d == '0) : (low_d == '0));
        events[EV_CMPC] = adv & (low_d == LVL_C);
        wave_rise = wave_d & ~wave;
    end

    // Count and wave registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            wave <= WAVE_RST;
        end else begin
            cnt  <= cnt_d;
            wave <= wave_d;
        end
    end

    AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && step && !sync && (&cnt[LO_W-1:0])) |=> (cnt == '0)); // R3
    AST_WAVE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[LO_W-1:0] == LVL_A) |-> wave); // R4
    AST_WAVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[LO_W-1:0] == LVL_C) |-> !wave); // R4
    AST_WIDE_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && step && !sync) |=> (cnt == $past(cnt) + W'(1))); // R10
endmodule

// File: rtl/casc_high_chan.sv
// High channel: free-running counter clocked by the low wave's rising edge
// or by the prescaled tick.
// Assumes: lo_rise is valid for the edge on which the low count changes.
module casc_high_chan
    import casc_pkg::*;
#(
    parameter int HI_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    input  logic             run,
    input  logic             src_sel,
    input  logic             tick,
    input  logic             lo_rise,
    output logic [HI_W-1:0]  cnt,
    output logic [IRQ_W-1:0] events
);
    logic step;
    logic [HI_W-1:0] inc;

    // Source selection and event flags
    always_comb begin
        step = run & (src_sel ? lo_rise : tick);
        inc  = cnt + HI_W'(1);
        events = '0;
        events[EV_WRAP] = step & ~sync & (inc == '0);
    end

    // High count register
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (sync) cnt <= '0;
        else if (step) cnt <= inc;
    end

    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sync) |=> $stable(cnt)); // R10
    AST_HI_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_sel && tick && !sync) |=> (cnt == $past(cnt) + HI_W'(1))); // R6
endmodule

// File: rtl/casc_timebase.sv
// Cascaded timebase top: two channels joined into one wide free-running count.
// Assumes: single_mode and hi_src_sel are static while counting; a sync is
// issued after a mode change.
module casc_timebase
    import casc_pkg::*;
#(
    parameter int LO_W  = 16,
    parameter int HI_W  = 16,
    parameter int CMP_A = 0,
    parameter int CMP_C = 32768
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 single_mode,
    input  logic                 hi_src_sel,
    input  logic [1:0]           clk_en_cmd,
    input  logic [1:0]           clk_dis_cmd,
    input  logic                 sync_cmd,
    input  logic [1:0]           irq_en_wr,
    input  logic [1:0]           irq_dis_wr,
    input  logic [IRQ_W-1:0]     irq_wdata,
    output logic [1:0]           clk_on,
    output logic                 lo_wave,
    output logic [1:0]           irq,
    output logic [LO_W-1:0]      lo_count,
    output logic [HI_W-1:0]      hi_count,
    output logic [LO_W+HI_W-1:0] count_all
);
    localparam int W = LO_W + HI_W;

    logic [W-1:0]     lo_cnt;
    logic             lo_rise;
    logic [IRQ_W-1:0] ev [2];

    // One control block per channel
    for (genvar ch = 0; ch < 2; ch++) begin : g_ctl
        casc_chan_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_cmd   (clk_en_cmd[ch]),
            .dis_cmd  (clk_dis_cmd[ch]),
            .msk_set  (irq_en_wr[ch]),
            .msk_clr  (irq_dis_wr[ch]),
            .msk_data (irq_wdata),
            .events   (ev[ch]),
            .clk_on   (clk_on[ch]),
            .irq      (irq[ch])
        );
    end

    casc_low_chan #(.LO_W(LO_W), .HI_W(HI_W), .CMP_A(CMP_A), .CMP_C(CMP_C)) u_low (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync      (sync_cmd),
        .step      (tick & clk_on[0]),
        .wide      (single_mode),
        .cnt       (lo_cnt),
        .wave      (lo_wave),
        .wave_rise (lo_rise),
        .events    (ev[0])
    );

    casc_high_chan #(.HI_W(HI_W)) u_high (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync    (sync_cmd),
        .run     (clk_on[1] & ~single_mode),
        .src_sel (hi_src_sel),
        .tick    (tick),
        .lo_rise (lo_rise),
        .cnt     (hi_count),
        .events  (ev[1])
    );

    // Output views of the counters
    always_comb begin
        lo_count  = lo_cnt[LO_W-1:0];
        count_all = single_mode ? lo_cnt : {hi_count, lo_cnt[LO_W-1:0]};
    end

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_cmd |=> (count_all == '0)); // R8
    AST_CASCADE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!single_mode && hi_src_sel && clk_on[1] && clk_on[0] && tick && !sync_cmd
         && (&lo_count)) |=> (hi_count == $past(hi_count) + HI_W'(1))); // R5
endmodule

// File: tb/casc_timebase_bench.sv
module casc_timebase_bench;
    localparam int LO_W = 4;
    localparam int HI_W = 4;
    localparam int W    = LO_W + HI_W;
    localparam int CC   = 8;
    localparam int LMOD = 1 << LO_W;
    localparam int HMOD = 1 << HI_W;
    localparam int WMOD = 1 << W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, single_mode = 1'b0, hi_src_sel = 1'b1, sync_cmd = 1'b0;
    logic [1:0] clk_en_cmd = '0, clk_dis_cmd = '0, irq_en_wr = '0, irq_dis_wr = '0;
    logic [7:0] irq_wdata = '0;
    logic [1:0] clk_on, irq;
    logic lo_wave;
    logic [LO_W-1:0] lo_count;
    logic [HI_W-1:0] hi_count;
    logic [W-1:0] count_all;

    int checks = 0, failures = 0;
    int m_lo = 0, m_hi = 0;
    bit on0 = 0, on1 = 0;
    logic [7:0] mk0 = '0, mk1 = '0;
    bit done = 0;

    always #10 clk = ~clk;

    casc_timebase #(.LO_W(LO_W), .HI_W(HI_W), .CMP_A(0), .CMP_C(CC)) u_casc_timebase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .single_mode(single_mode),
        .hi_src_sel(hi_src_sel), .clk_en_cmd(clk_en_cmd), .clk_dis_cmd(clk_dis_cmd),
        .sync_cmd(sync_cmd), .irq_en_wr(irq_en_wr), .irq_dis_wr(irq_dis_wr),
        .irq_wdata(irq_wdata), .clk_on(clk_on), .lo_wave(lo_wave), .irq(irq),
        .lo_count(lo_count), .hi_count(hi_count), .count_all(count_all)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock edge: model update, then compare every output
    task automatic cyc(input logic tk);
        bit s0, wr0, cc0, hs, hw, rise, syn;
        tick = tk;
        @(posedge clk);
        syn = sync_cmd;
        s0 = tk && on0;
        wr0 = 0; cc0 = 0; hw = 0;
        if (syn) begin
            m_lo = 0; m_hi = 0;
        end else begin
            if (s0) m_lo = single_mode ? (m_lo + 1) % WMOD : (m_lo % LMOD + 1) % LMOD;
            wr0 = s0 && (single_mode ? (m_lo == 0) : (m_lo % LMOD == 0));
            cc0 = s0 && (m_lo % LMOD == CC);
            rise = s0 && (m_lo % LMOD == 0);
            hs = on1 && !single_mode && (hi_src_sel ? rise : tk);
            if (hs) begin
                m_hi = (m_hi + 1) % HMOD;
                hw = (m_hi == 0);
            end
        end
        if (irq_en_wr[0])  mk0 = mk0 | irq_wdata;
        if (irq_dis_wr[0]) mk0 = mk0 & ~irq_wdata;
        if (irq_en_wr[1])  mk1 = mk1 | irq_wdata;
        if (irq_dis_wr[1]) mk1 = mk1 & ~irq_wdata;
        if (clk_dis_cmd[0]) on0 = 0; else if (clk_en_cmd[0]) on0 = 1;
        if (clk_dis_cmd[1]) on1 = 0; else if (clk_en_cmd[1]) on1 = 1;
        #1;
        check(syn ? "R8 lo" : (on0 ? "R3 lo" : "R2 lo"), int'(lo_count), m_lo % LMOD);
        check(syn ? "R8 hi" : (single_mode ? "R10 hi" : (hi_src_sel ? "R5 hi" : "R6 hi")),
              int'(hi_count), m_hi);
        check(syn ? "R8 all" : (single_mode ? "R10 all" : "R7 all"), int'(count_all),
              single_mode ? m_lo : m_hi * LMOD + m_lo % LMOD);
        check("R4 wave", int'(lo_wave), (m_lo % LMOD < CC) ? 1 : 0);
        check("R9 irq0", int'(irq[0]), ((mk0[0] && wr0) || (mk0[1] && cc0)) ? 1 : 0);
        check("R9 irq1", int'(irq[1]), (mk1[0] && hw) ? 1 : 0);
        check("R2 clk_on", int'(clk_on), int'({on1, on0}));
        clk_en_cmd = '0; clk_dis_cmd = '0; irq_en_wr = '0; irq_dis_wr = '0;
        sync_cmd = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check("R1 lo", int'(lo_count), 0);
        check("R1 hi", int'(hi_count), 0);
        check("R1 clk_on", int'(clk_on), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 wave", int'(lo_wave), 1);
        // R2: ticks without clock on have no effect
        for (int i = 0; i < 6; i++) cyc(1'b1);
        // R2: switch both clocks on; R9 masks: low wrap+cmpC, high wrap
        clk_en_cmd = 2'b11; irq_en_wr = 2'b01; irq_wdata = 8'h03;
        cyc(1'b1);
        irq_en_wr = 2'b10; irq_wdata = 8'h01;
        cyc(1'b1);
        // R3/R4/R5/R7/R9 sweep with an irregular tick pattern
        for (int i = 0; i < 700; i++) cyc((i % 5) != 2);
        // R9: clear all low mask bits, set in the same write loses
        irq_dis_wr = 2'b01; irq_en_wr = 2'b01; irq_wdata = 8'hFF;
        cyc(1'b1);
        for (int i = 0; i < 60; i++) cyc(1'b1);
        // R2: off wins over on for the low channel
        clk_dis_cmd = 2'b01; clk_en_cmd = 2'b01;
        cyc(1'b1);
        for (int i = 0; i < 20; i++) cyc(1'b1);
        clk_en_cmd = 2'b01;
        cyc(1'b1);
        for (int i = 0; i < 13; i++) cyc(1'b1);
        // R8: sync while counting
        sync_cmd = 1'b1;
        cyc(1'b1);
        // R6: high channel on tick directly
        hi_src_sel = 1'b0;
        for (int i = 0; i < 40; i++) cyc((i % 3) != 0);
        // R10: single wide counter, high channel idle
        single_mode = 1'b1; sync_cmd = 1'b1;
        cyc(1'b0);
        for (int i = 0; i < 600; i++) cyc(1'b1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule